// File: doc/BRIEF.md
# Translation-unit command and status controller

This block is the register-mapped control front of an address translation unit. Software programs the base address of the top-level translation directory, masks and acknowledges interrupt sources, and drives the unit's operating mode by writing command codes. The block holds the paging-enabled and stall-active state and drives them to the table walker. It also issues one-cycle strobes that flush the whole translation cache, invalidate a single cached line, or release a transaction held by a page fault.

A forced-reset command clears the directory base register, and software detects completion by reading it back as zero. Leaving the stall state lets paging resume without a further command. Page-fault and bus-error events from the walker set sticky raw interrupt bits. The interrupt output is asserted while any raw bit is set and enabled in the mask. Writing ones to the clear register drops those bits.

Register map, byte offsets on `bus_addr`: 0x00 directory base (read/write), 0x04 status (read-only), 0x08 command (write-only), 0x0C line invalidate (write-only), 0x10 raw interrupts (read-only), 0x14 interrupt mask (read/write), 0x18 interrupt clear (write-only), 0x1C masked pending interrupts (read-only). Write-only and unused offsets read as zero. Reads are combinational. Writes take effect at the clock edge where `bus_wr` is high.

Top module: `xlat_ctrl`

## Requirements
- R1: While `rst_n` is low and after its release, the directory base, status, raw, mask and pending registers read 0, and `walk_en`, `walk_stall`, `flush_all`, `line_inv`, `fault_release` and `irq` are 0.
- R2: A write to offset 0x00 stores only the address bits. With EXT_FMT=0 bits 31:12 are kept and bits 11:0 read back as 0. With EXT_FMT=1 bits 31:4 are kept.
- R3: The command code is `bus_wdata[2:0]` at offset 0x08, and the upper bits are ignored. Code 0 sets paging and code 1 clears it. The result shows in status bit 0 and on `walk_en` from the cycle after the write.
- R4: Code 2 sets the stall state (status bit 1, `walk_stall`) only when paging is enabled at the time of the write. Otherwise it changes nothing.
- R5: Code 3 clears the stall state and leaves the paging bit as it was, so a paging unit resumes.
- R6: Code 4 produces a one-cycle `flush_all` pulse in the cycle after the write. Code 5 produces a one-cycle `fault_release` pulse in the cycle after the write.
- R7: A write to offset 0x0C produces a one-cycle `line_inv` pulse in the next cycle, with `line_inv_addr` equal to the written data, and `flush_all` stays low.
- R8: Code 6 clears the directory base to zero from the next cycle on and leaves paging and stall unchanged.
- R9: A high `ev_fault` sets raw bit 0 and a high `ev_buserr` sets raw bit 1 (offset 0x10). The bits are set whatever the mask holds and stay set until cleared.
- R10: Mask bits [1:0] at offset 0x14 enable raw bits 0 and 1. Offset 0x1C reads raw AND mask, and `irq` is high exactly when that value is non-zero. A zero mask keeps `irq` low.
- R11: A write to offset 0x18 clears the raw bits written as one and leaves the others. An event arriving in the same cycle as the clear of its bit leaves that bit set.
- R12: Code 7 is ignored: no state changes and no strobe is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write enable |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Combinational read data for `bus_addr` |
| ev_fault | input | 1 | Page-fault event from the walker |
| ev_buserr | input | 1 | Bus-error event from the walker |
| walk_en | output | 1 | Paging enabled |
| walk_stall | output | 1 | Stall active |
| flush_all | output | 1 | Flush-all-translations strobe |
| line_inv | output | 1 | Single-line invalidate strobe |
| line_inv_addr | output | DW (32) | Address to invalidate |
| fault_release | output | 1 | Release of the faulted transaction |
| irq | output | 1 | Interrupt request |

## Verification
An interrupt event and a software clear of the same raw bit can fall in the same cycle. The bench provokes this by driving `ev_fault` together with a clear write of ones, both directly and repeatedly in a randomized phase. It judges the outcome from the raw, pending and `irq` values in the following cycle, which must show the bit still set. A mask write coinciding with an event on the other source is exercised the same way. A cycle-by-cycle behavioural model compares every output and the read data for the currently addressed register.

// File: rtl/xlat_ctrl_pkg.sv
// Shared definitions for the translation-unit controller: command codes,
// register offsets and interrupt source positions.
package xlat_ctrl_pkg;
    localparam int OFS_W  = 5;
    localparam int N_IRQ  = 2;
    localparam int IRQ_FAULT = 0;
    localparam int IRQ_BUS   = 1;

    typedef enum logic [2:0] {
        CMD_PAGE_ON    = 3'd0,
        CMD_PAGE_OFF   = 3'd1,
        CMD_STALL_ON   = 3'd2,
        CMD_STALL_OFF  = 3'd3,
        CMD_FLUSH      = 3'd4,
        CMD_FAULT_DONE = 3'd5,
        CMD_FORCE_RST  = 3'd6,
        CMD_NONE       = 3'd7
    } xcmd_e;

    localparam logic [OFS_W-1:0] OFS_BASE = 5'h00;
    localparam logic [OFS_W-1:0] OFS_STAT = 5'h04;
    localparam logic [OFS_W-1:0] OFS_CMD  = 5'h08;
    localparam logic [OFS_W-1:0] OFS_LINE = 5'h0C;
    localparam logic [OFS_W-1:0] OFS_RAW  = 5'h10;
    localparam logic [OFS_W-1:0] OFS_MASK = 5'h14;
    localparam logic [OFS_W-1:0] OFS_CLR  = 5'h18;
    localparam logic [OFS_W-1:0] OFS_PEND = 5'h1C;
endpackage

// File: rtl/xlat_mode_fsm.sv
// Mode state and command strobes.
// Decodes a command code written by software. It keeps the paging and stall
// bits and raises one-cycle flush and fault-release strobes.
// Assumes cmd_vld is a single-cycle qualifier of cmd_code.
module xlat_mode_fsm
    import xlat_ctrl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_vld,
    input  logic [2:0] cmd_code,
    output logic       paging_q,
    output logic       stall_q,
    output logic       flush_q,
    output logic       release_q,
    output logic       base_clr
);
    xcmd_e code;

    // Name the raw code as a command.
    always_comb code = xcmd_e'(cmd_code);

    // Force-reset request to the directory base register.
    always_comb base_clr = cmd_vld && (code == CMD_FORCE_RST);

    // Mode bits and strobes; strobes last one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            paging_q  <= 1'b0;
            stall_q   <= 1'b0;
            flush_q   <= 1'b0;
            release_q <= 1'b0;
        end else begin
            flush_q   <= 1'b0;
            release_q <= 1'b0;
            if (cmd_vld) begin
                case (code)
                    CMD_PAGE_ON:    paging_q  <= 1'b1;
                    CMD_PAGE_OFF:   paging_q  <= 1'b0;
                    CMD_STALL_ON:   if (paging_q) stall_q <= 1'b1;
                    CMD_STALL_OFF:  stall_q   <= 1'b0;
                    CMD_FLUSH:      flush_q   <= 1'b1;
                    CMD_FAULT_DONE: release_q <= 1'b1;
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/xlat_base_reg.sv
// Directory base register.
// Stores only the address bits of a written value. EXT_FMT selects how many
// low bits are dropped. A clear request forces the register to zero.
// Assumes wr and clr never arrive in the same cycle (single write port).
module xlat_base_reg #(
    parameter int DW      = 32,
    parameter bit EXT_FMT = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic          clr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] base_q
);
    localparam int DROP_LSB = EXT_FMT ? 4 : 12;
    localparam logic [DW-1:0] KEEP_MASK = {{(DW-DROP_LSB){1'b1}}, {DROP_LSB{1'b0}}};

    logic [DW-1:0] wkeep;

    // Pick the stored bit set for the selected format.
    generate
        if (EXT_FMT) begin : g_ext
            always_comb wkeep = wdata & KEEP_MASK;
        end else begin : g_base
            always_comb wkeep = {wdata[DW-1:DROP_LSB], {DROP_LSB{1'b0}}};
        end
    endgenerate

    // Register update: clear wins, then write.
    always_ff @(posedge clk) begin
        if (!rst_n)   base_q <= '0;
        else if (clr) base_q <= '0;
        else if (wr)  base_q <= wkeep;
    end
endmodule

// File: rtl/xlat_irq_unit.sv
// Interrupt sources.
// Keeps sticky raw bits set by walker events and cleared by write-one
// acknowledges; holds the enable mask and forms the interrupt output.
// An event in the same cycle as the clear of its bit keeps the bit set.
module xlat_irq_unit #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ev,
    input  logic         mask_wr,
    input  logic         clr_wr,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] raw_q,
    output logic [N-1:0] mask_q,
    output logic         irq
);
    // One sticky bit per source.
    generate
        for (genvar i = 0; i < N; i++) begin : g_src
            always_ff @(posedge clk) begin
                if (!rst_n) raw_q[i] <= 1'b0;
                else        raw_q[i] <= ev[i] | (raw_q[i] & ~(clr_wr & wdata[i]));
            end
        end
    endgenerate

    // Enable mask.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_wr) mask_q <= wdata;
    end

    // Interrupt while any enabled source is pending.
    always_comb irq = |(raw_q & mask_q);
endmodule

// File: rtl/xlat_ctrl.sv
// Translation-unit command and status controller (top).
// Decodes register writes, hosts the base register, mode state and interrupt
// unit, registers the line-invalidate strobe and muxes read data.
// Assumes one register access per cycle; reads are combinational.
module xlat_ctrl
    import xlat_ctrl_pkg::*;
#(
    parameter int DW      = 32,
    parameter bit EXT_FMT = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [OFS_W-1:0] bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    input  logic             ev_fault,
    input  logic             ev_buserr,
    output logic             walk_en,
    output logic             walk_stall,
    output logic             flush_all,
    output logic             line_inv,
    output logic [DW-1:0]    line_inv_addr,
    output logic             fault_release,
    output logic             irq
);
    logic          wr_base, wr_cmd, wr_line, wr_mask, wr_clr;
    logic          base_clr;
    logic [DW-1:0] base_q;
    logic [N_IRQ-1:0] raw_q, mask_q, ev_vec;

    // Write decode per register.
    always_comb begin
        wr_base = bus_wr && (bus_addr == OFS_BASE);
        wr_cmd  = bus_wr && (bus_addr == OFS_CMD);
        wr_line = bus_wr && (bus_addr == OFS_LINE);
        wr_mask = bus_wr && (bus_addr == OFS_MASK);
        wr_clr  = bus_wr && (bus_addr == OFS_CLR);
    end

    // Event vector in source order.
    always_comb begin
        ev_vec = '0;
        ev_vec[IRQ_FAULT] = ev_fault;
        ev_vec[IRQ_BUS]   = ev_buserr;
    end

    xlat_mode_fsm u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_vld   (wr_cmd),
        .cmd_code  (bus_wdata[2:0]),
        .paging_q  (walk_en),
        .stall_q   (walk_stall),
        .flush_q   (flush_all),
        .release_q (fault_release),
        .base_clr  (base_clr)
    );

    xlat_base_reg #(.DW(DW), .EXT_FMT(EXT_FMT)) u_base (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (wr_base),
        .clr    (base_clr),
        .wdata  (bus_wdata),
        .base_q (base_q)
    );

    xlat_irq_unit #(.N(N_IRQ)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev      (ev_vec),
        .mask_wr (wr_mask),
        .clr_wr  (wr_clr),
        .wdata   (bus_wdata[N_IRQ-1:0]),
        .raw_q   (raw_q),
        .mask_q  (mask_q),
        .irq     (irq)
    );

    // Single-line invalidate strobe and its address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_inv      <= 1'b0;
            line_inv_addr <= '0;
        end else begin
            line_inv <= wr_line;
            if (wr_line) line_inv_addr <= bus_wdata;
        end
    end

    // Read mux; write-only and unused offsets return zero.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_BASE: bus_rdata = base_q;
            OFS_STAT: bus_rdata[1:0] = {walk_stall, walk_en};
            OFS_RAW:  bus_rdata[N_IRQ-1:0] = raw_q;
            OFS_MASK: bus_rdata[N_IRQ-1:0] = mask_q;
            OFS_PEND: bus_rdata[N_IRQ-1:0] = raw_q & mask_q;
            default: ;
        endcase
    end
endmodule

// File: rtl/xlat_ctrl_chk.sv
// Property checker for xlat_ctrl, attached by bind.
// Relates command and event inputs to the outputs and state one cycle later.
module xlat_ctrl_chk
    import xlat_ctrl_pkg::*;
#(
    parameter int DW = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic [OFS_W-1:0] bus_addr,
    input logic [DW-1:0]    bus_wdata,
    input logic             ev_fault,
    input logic             walk_en,
    input logic             walk_stall,
    input logic             flush_all,
    input logic             line_inv,
    input logic             fault_release,
    input logic             irq,
    input logic [DW-1:0]    dir_q,
    input logic [N_IRQ-1:0] raw_q,
    input logic [N_IRQ-1:0] mask_q
);
    logic       cmd_w;
    logic [2:0] code;
    always_comb cmd_w = bus_wr && (bus_addr == OFS_CMD);
    always_comb code  = bus_wdata[2:0];

    p_paging_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_w && code == 3'd0 |=> walk_en);
    p_stall_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_w && code == 3'd2 && !walk_en && !walk_stall |=> !walk_stall);
    p_unstall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_w && code == 3'd3 |=> !walk_stall && walk_en == $past(walk_en));
    p_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_w && code == 3'd4 |=> flush_all);
    p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_w && code == 3'd5 |=> fault_release);
    p_line_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == OFS_LINE |=> line_inv && !flush_all);
    p_force_rst_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_w && code == 3'd6 |=> dir_q == '0);
    p_fault_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ev_fault |=> raw_q[IRQ_FAULT]);
    p_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mask_q == '0 |-> !irq);
    p_no_raw_r10: assert property (@(posedge clk) disable iff (!rst_n)
        raw_q == '0 |-> !irq);
    p_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_w && code == 3'd7 |=> !flush_all && !fault_release
                                  && $stable(walk_en) && $stable(walk_stall));
endmodule

bind xlat_ctrl xlat_ctrl_chk #(.DW(DW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_wr        (bus_wr),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .ev_fault      (ev_fault),
    .walk_en       (walk_en),
    .walk_stall    (walk_stall),
    .flush_all     (flush_all),
    .line_inv      (line_inv),
    .fault_release (fault_release),
    .irq           (irq),
    .dir_q         (base_q),
    .raw_q         (raw_q),
    .mask_q        (mask_q)
);

// File: tb/tb_xlat_ctrl.sv
`timescale 1ns/1ps
// Bench for xlat_ctrl: behavioural model updated on each rising edge and
// compared 5 ns later, plus directed checks at falling edges.
module tb_xlat_ctrl;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_wr;
    logic [4:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        ev_fault, ev_buserr;
    logic        walk_en, walk_stall, flush_all, line_inv, fault_release, irq;
    logic [31:0] line_inv_addr;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 0;

    // model state
    bit          m_pg, m_st, m_fl, m_rl, m_li;
    logic [31:0] m_dir, m_la;
    logic [1:0]  m_raw, m_mask;

    always #10 clk = ~clk;

    xlat_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_fault(ev_fault),
        .ev_buserr(ev_buserr), .walk_en(walk_en), .walk_stall(walk_stall),
        .flush_all(flush_all), .line_inv(line_inv), .line_inv_addr(line_inv_addr),
        .fault_release(fault_release), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] m_read(input logic [4:0] a);
        case (a)
            5'h00: return m_dir;
            5'h04: return {30'd0, m_st, m_pg};
            5'h10: return {30'd0, m_raw};
            5'h14: return {30'd0, m_mask};
            5'h1C: return {30'd0, m_raw & m_mask};
            default: return 32'd0;
        endcase
    endfunction

    function automatic string rd_tag(input logic [4:0] a);
        case (a)
            5'h00: return "R2 R8 base read";
            5'h04: return "R3 R4 R5 status read";
            5'h10: return "R9 R11 raw read";
            5'h14, 5'h1C: return "R10 mask/pending read";
            default: return "R12 empty read";
        endcase
    endfunction

    // Model update on the edge, comparison 5 ns later.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_pg = 0; m_st = 0; m_fl = 0; m_rl = 0; m_li = 0;
            m_dir = 0; m_la = 0; m_raw = 0; m_mask = 0;
        end else begin
            m_fl = 0; m_rl = 0; m_li = 0;
            if (bus_wr) begin
                case (bus_addr)
                    5'h00: m_dir = bus_wdata & 32'hFFFF_F000;
                    5'h08: case (bus_wdata[2:0])
                        3'd0: m_pg = 1;
                        3'd1: m_pg = 0;
                        3'd2: if (m_pg) m_st = 1;
                        3'd3: m_st = 0;
                        3'd4: m_fl = 1;
                        3'd5: m_rl = 1;
                        3'd6: m_dir = 0;
                        default: ;
                    endcase
                    5'h0C: begin m_li = 1; m_la = bus_wdata; end
                    5'h14: m_mask = bus_wdata[1:0];
                    default: ;
                endcase
            end
            m_raw = (m_raw & ~((bus_wr && bus_addr == 5'h18) ? bus_wdata[1:0] : 2'b00))
                    | {ev_buserr, ev_fault};
        end
        #5;
        if (!done) begin
            chk("R3 walk_en", walk_en, m_pg);
            chk("R4 R5 walk_stall", walk_stall, m_st);
            chk("R6 flush_all", flush_all, m_fl);
            chk("R6 fault_release", fault_release, m_rl);
            chk("R7 line_inv", line_inv, m_li);
            if (m_li) chk("R7 line_inv_addr", line_inv_addr, m_la);
            chk("R10 irq", irq, |(m_raw & m_mask));
            chk(rd_tag(bus_addr), bus_rdata, m_read(bus_addr));
        end
        if (cycles > 20000 && !done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog expired act=%0d exp=<20000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // One cycle of stimulus, applied at a falling edge.
    task automatic step(input bit wr, input logic [4:0] a, input logic [31:0] d,
                        input bit ef = 0, input bit eb = 0);
        bus_wr = wr; bus_addr = a; bus_wdata = d; ev_fault = ef; ev_buserr = eb;
        @(negedge clk);
        bus_wr = 0; ev_fault = 0; ev_buserr = 0;
    endtask

    initial begin
        rst_n = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0; ev_fault = 0; ev_buserr = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 base", bus_rdata, 32'd0);
        chk("R1 walk_en", walk_en, 0);
        chk("R1 irq", irq, 0);
        chk("R1 strobes", {flush_all, line_inv, fault_release}, 3'b000);
        rst_n = 1;
        step(0, 5'h04, 0);
        chk("R1 status after release", bus_rdata, 32'd0);

        // R2: address bits kept
        step(1, 5'h00, 32'hABCD_E123);
        chk("R2 base drop low bits", bus_rdata, 32'hABCD_E000);

        // R4: stall refused while paging off
        step(1, 5'h08, 32'd2);
        chk("R4 stall ignored without paging", walk_stall, 0);
        // R3, R4, R5
        step(1, 5'h08, 32'hFFFF_FFF8);
        chk("R3 paging on, upper bits ignored", walk_en, 1);
        step(1, 5'h08, 32'd2);
        chk("R4 stall with paging", walk_stall, 1);
        step(1, 5'h08, 32'd3, 1);
        chk("R5 stall off paging kept", {walk_stall, walk_en}, 2'b01);

        // R6 strobes
        step(1, 5'h08, 32'd4);
        chk("R6 flush pulse", flush_all, 1);
        step(1, 5'h08, 32'd5);
        chk("R6 flush one cycle", flush_all, 0);
        chk("R6 release pulse", fault_release, 1);

        // R7 line invalidate
        step(1, 5'h0C, 32'h1234_5678);
        chk("R7 line strobe", {line_inv, flush_all}, 2'b10);
        chk("R7 line addr", line_inv_addr, 32'h1234_5678);

        // R12 ignored code
        step(1, 5'h08, 32'd7);
        chk("R12 no strobe", {flush_all, fault_release, line_inv}, 3'b000);
        chk("R12 mode kept", {walk_stall, walk_en}, 2'b01);

        // R8 forced reset
        step(1, 5'h08, 32'd6);
        step(0, 5'h00, 0);
        chk("R8 base zero", bus_rdata, 32'd0);
        chk("R8 paging kept", walk_en, 1);

        // R9..R11 interrupts (raw bit0 set earlier by R5 step)
        step(0, 5'h10, 0);
        chk("R9 raw fault sticky, mask zero", bus_rdata, 32'd1);
        chk("R10 silent with zero mask", irq, 0);
        step(1, 5'h14, 32'd1, 0, 1);
        chk("R10 irq with mask", irq, 1);
        step(0, 5'h1C, 0);
        chk("R10 pending", bus_rdata, 32'd1);
        step(1, 5'h18, 32'd1);
        chk("R11 clear fault, bus error left", irq, 0);
        step(1, 5'h18, 32'd3, 1, 0);
        step(0, 5'h10, 0);
        chk("R11 event beats clear", bus_rdata, 32'd1);
        step(1, 5'h14, 32'd0);
        chk("R10 mask zero silences", irq, 0);

        // randomized phase
        for (int i = 0; i < 400; i++) begin
            logic [4:0] a;
            a = 5'(($urandom % 8) * 4);
            step($urandom % 3 != 0, a, (a == 5'h08) ? $urandom % 8 : $urandom,
                 ($urandom % 5) == 0, ($urandom % 7) == 0);
        end
        step(0, 5'h00, 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule